// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between the deserializer of a byte-wide UART and the register bus. Each character that the receiver core finishes arrives here with its parity and framing error indications. The block stores the character and its flags together in one slot of a first-in first-out store, 16 slots deep by default. A read strobe removes the oldest slot. The byte is presented on a data port, and the three error flags that belong to that same byte are presented on a separate character-status port. Software reads the byte and then the status, and the pair always describes one character.

A small configuration field chooses between buffered operation and single-character operation, and sets a fill limit. In buffered operation the limit can never go below half the depth. A sticky threshold flag, which also drives the receive request, sets when occupancy goes above that limit. Software acknowledges the flag by writing a one to its status position. A character that arrives while the store is full is lost, and the loss is recorded on the newest stored character. A soft-clear pulse discards all contents and flags.

Top module: `uart_rx_buffer`

## Requirements
- R1: Characters leave in the order they arrived, and up to DEPTH (16) characters are held with none lost.
- R2: A read strobe while the store is not empty removes the oldest character. Its byte appears on `rd_data` one clock edge after the strobe.
- R3: `char_status` gives the flags of the character last removed: bit 0 parity error, bit 1 framing error, bit 2 overrun, bits 7:3 zero. The parity and framing flags are those sampled with the character on its arrival.
- R4: A character that arrives while the store is at capacity, with no removal in the same cycle, is dropped, and bit 2 (overrun) is set on the most recently stored entry. If a removal happens in the same cycle, the arriving character is accepted.
- R5: A read strobe while the store is empty changes neither `rd_data` nor `char_status` nor the occupancy.
- R6: `fifo_status` bit 2 is 1 exactly when the store is empty, bit 3 is the threshold flag, and all other bits are 0.
- R7: A configuration write (`wr_sel`=0) sets the buffered-mode enable from `wr_data` bit 3 and the limit code from bits 2:0. In buffered mode the limit is DEPTH/2 + code. The threshold flag sets on the first clock edge at which the stored occupancy is above the limit. This is one edge after the occupancy change.
- R8: The threshold flag stays set until a status write (`wr_sel`=1) with `wr_data` bit 3 = 1. The flag does not clear if the occupancy is still above the limit at that edge. A status write with bit 3 = 0 has no effect.
- R9: With buffered mode off (the reset state), capacity is one character and the limit is zero. Holding one character therefore sets the threshold flag.
- R10: `rx_req` equals the threshold flag at all times.
- R11: A `soft_clr` pulse empties the store and clears the threshold flag, `char_status` and `rd_data` at the next edge. The configuration is kept, and a character arriving in that cycle is discarded.
- R12: After reset, `rd_data` and `char_status` are 0, `fifo_status` is 0x04, `rx_req` is 0, and buffered mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | One-cycle pulse that discards contents and flags |
| in_valid | input | 1 | Receiver core delivers a character this cycle |
| in_data | input | DATA_W (8) | Received character |
| in_par_err | input | 1 | Parity error of the delivered character |
| in_frm_err | input | 1 | Framing error of the delivered character |
| rd_stb | input | 1 | Remove the oldest character |
| wr_stb | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects configuration, 1 selects status acknowledge |
| wr_data | input | 4 | Write data: bit 3 mode enable or acknowledge, bits 2:0 limit code |
| rd_data | output | DATA_W (8) | Byte of the character last removed |
| char_status | output | 8 | Error flags of the character last removed |
| fifo_status | output | 8 | Empty flag on bit 2, threshold flag on bit 3 |
| rx_req | output | 1 | Receive request |

## Verification
A character accepted on one edge is counted in the empty bit of `fifo_status` right after that edge. The threshold flag and `rx_req` follow one edge later, because they are computed from the registered occupancy. A removal shows its byte and flags on `rd_data` and `char_status` right after the edge that saw the strobe. The bench drives all stimulus on the falling edge. Its behavioural model advances on the rising edge with the same one-stage lag for the flag, and it compares all four outputs on every falling edge. The directed checks that probe the flag latency look once just after the occupancy change, expecting no flag yet, and again one cycle later, expecting the flag.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int CFG_W        = 4;
  localparam int STAT_W       = 8;
  localparam int ST_EMPTY_BIT = 2;
  localparam int ST_THR_BIT   = 3;
  localparam int CFG_MODE_BIT = 3;

  // Per-character error record; bit order matches the char_status byte
  typedef struct packed {
    logic ovr;
    logic frm;
    logic par;
  } rxb_err_t;

  // Number of characters the store accepts in the current mode
  function automatic int unsigned rxb_cap(input logic fifo_on, input int unsigned depth);
    return fifo_on ? depth : 32'd1;
  endfunction

  // Occupancy above which the threshold flag sets
  function automatic int unsigned rxb_limit(input logic fifo_on, input int unsigned code,
                                            input int unsigned depth);
    return fifo_on ? (depth / 2) + code : 32'd0;
  endfunction

endpackage

// File: rtl/rxb_cfg.sv
module rxb_cfg
  import rxb_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  output logic              fifo_on,
  output logic [CODE_W-1:0] thr_code,
  output logic              ack
);

  // Configuration field survives soft clear; only reset returns it to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on  <= 1'b0;
      thr_code <= '0;
    end else if (wr_stb && !wr_sel) begin
      fifo_on  <= wr_data[CFG_MODE_BIT];
      thr_code <= wr_data[CODE_W-1:0];
    end
  end

  assign ack = wr_stb && wr_sel && wr_data[ST_THR_BIT];

endmodule

// File: rtl/rxb_ptrs.sv
module rxb_ptrs
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             in_valid,
  input  logic             rd_stb,
  input  logic             fifo_on,
  output logic [AW-1:0]    head,
  output logic [AW-1:0]    tail,
  output logic [AW-1:0]    last_idx,
  output logic [CNT_W-1:0] count,
  output logic             push_ev,
  output logic             pop_ev,
  output logic             ovr_ev
);

  logic full;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] wrap_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign full     = 32'(count) >= rxb_cap(fifo_on, DEPTH);
  assign pop_ev   = rd_stb && (count != '0) && !soft_clr;
  // A removal in the same cycle frees the slot the arrival needs
  assign push_ev  = in_valid && !soft_clr && (!full || pop_ev);
  assign ovr_ev   = in_valid && !soft_clr && full && !pop_ev;
  assign last_idx = wrap_dec(tail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (soft_clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop_ev)  head <= wrap_inc(head);
      if (push_ev) tail <= wrap_inc(tail);
      case ({push_ev, pop_ev})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              push_ev,
  input  logic [AW-1:0]     tail,
  input  logic [DATA_W-1:0] in_data,
  input  rxb_err_t          in_err,
  input  logic              ovr_ev,
  input  logic [AW-1:0]     last_idx,
  input  logic              pop_ev,
  input  logic [AW-1:0]     head,
  output logic [DATA_W-1:0] rd_data,
  output rxb_err_t          rd_err
);

  logic [DATA_W-1:0] data_q [DEPTH];
  rxb_err_t          err_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (push_ev) data_q[tail] <= in_data;
  end

  // Flags live beside each byte; overrun is attached to the newest slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) err_q[s] <= '0;
    end else if (soft_clr) begin
      for (int s = 0; s < DEPTH; s++) err_q[s] <= '0;
    end else begin
      if (push_ev) err_q[tail] <= in_err;
      if (ovr_ev)  err_q[last_idx].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= '0;
    end else if (soft_clr) begin
      rd_data <= '0;
      rd_err  <= '0;
    end else if (pop_ev) begin
      rd_data <= data_q[head];
      rd_err  <= err_q[head];
    end
  end

endmodule

// File: rtl/rxb_thresh.sv
module rxb_thresh
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic [CNT_W-1:0]  count,
  input  logic              fifo_on,
  input  logic [CODE_W-1:0] thr_code,
  input  logic              ack,
  output logic              above,
  output logic              flag
);

  assign above = 32'(count) > rxb_limit(fifo_on, 32'(thr_code), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (soft_clr) flag <= 1'b0;
    else               flag <= (flag && !ack) || above;
  end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] char_status,
  output logic [STAT_W-1:0] fifo_status,
  output logic              rx_req
);

  localparam int AW     = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CODE_W = $clog2(DEPTH / 2);

  logic              fifo_on_w;
  logic [CODE_W-1:0] thr_code_w;
  logic              ack_w;
  logic [AW-1:0]     head_w, tail_w, last_w;
  logic [CNT_W-1:0]  count_w;
  logic              push_w, pop_w, ovr_w;
  logic              above_w, flag_w;
  rxb_err_t          in_err_w, rd_err_w;

  assign in_err_w = '{ovr: 1'b0, frm: in_frm_err, par: in_par_err};

  rxb_cfg #(.CODE_W(CODE_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .fifo_on(fifo_on_w), .thr_code(thr_code_w), .ack(ack_w)
  );

  rxb_ptrs #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .in_valid(in_valid), .rd_stb(rd_stb),
    .fifo_on(fifo_on_w), .head(head_w), .tail(tail_w), .last_idx(last_w), .count(count_w),
    .push_ev(push_w), .pop_ev(pop_w), .ovr_ev(ovr_w)
  );

  rxb_store #(.DEPTH(DEPTH), .AW(AW), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push_ev(push_w), .tail(tail_w),
    .in_data(in_data), .in_err(in_err_w), .ovr_ev(ovr_w), .last_idx(last_w),
    .pop_ev(pop_w), .head(head_w), .rd_data(rd_data), .rd_err(rd_err_w)
  );

  rxb_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CODE_W(CODE_W)) thr_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .count(count_w), .fifo_on(fifo_on_w),
    .thr_code(thr_code_w), .ack(ack_w), .above(above_w), .flag(flag_w)
  );

  assign char_status = STAT_W'(rd_err_w);
  assign rx_req      = flag_w;

  always_comb begin
    fifo_status               = '0;
    fifo_status[ST_EMPTY_BIT] = (count_w == '0);
    fifo_status[ST_THR_BIT]   = flag_w;
  end

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_clr,
  input logic              rd_stb,
  input logic [CNT_W-1:0]  count,
  input logic              ovr_ev,
  input logic              above,
  input logic              ack,
  input logic [DATA_W-1:0] rd_data,
  input logic [STAT_W-1:0] char_status,
  input logic [STAT_W-1:0] fifo_status,
  input logic              rx_req
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH); // R1

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fifo_status[ST_EMPTY_BIT] && !soft_clr) |=> ($stable(rd_data) && $stable(char_status))); // R5

  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> (count == $past(count))); // R4

  AST_DROP_ONLY_WHEN_HOLDING: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |-> !fifo_status[ST_EMPTY_BIT]); // R4

  AST_LIMIT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (above && !soft_clr) |=> rx_req); // R7

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !above) |=> !rx_req); // R8

  AST_REQ_MIRRORS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req == fifo_status[ST_THR_BIT]); // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (fifo_status[ST_EMPTY_BIT] && (char_status == '0) && !rx_req)); // R11

endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rd_stb(rd_stb), .count(count_w),
  .ovr_ev(ovr_w), .above(above_w), .ack(ack_w), .rd_data(rd_data),
  .char_status(char_status), .fifo_status(fifo_status), .rx_req(rx_req)
);

// File: tb/uart_rx_buffer_tb_top.sv
module uart_rx_buffer_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n, soft_clr, in_valid, in_par_err, in_frm_err, rd_stb, wr_stb, wr_sel;
  logic [7:0] in_data, rd_data, char_status, fifo_status;
  logic [3:0] wr_data;
  logic       rx_req;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .in_valid(in_valid), .in_data(in_data),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data), .char_status(char_status),
    .fifo_status(fifo_status), .rx_req(rx_req)
  );

  // Behavioural reference: entry = {ovr, frm, par, byte}
  logic [10:0] mq[$];
  bit          m_flag, m_on;
  int          m_code;
  logic [7:0]  m_rdd, m_cst;

  always @(posedge clk) begin
    int  lim, cap, sz;
    bit  above, ack, pop, full;
    if (!rst_n) begin
      mq.delete(); m_flag = 0; m_on = 0; m_code = 0; m_rdd = 0; m_cst = 0;
    end else begin
      sz    = mq.size();
      lim   = m_on ? DEPTH / 2 + m_code : 0;
      cap   = m_on ? DEPTH : 1;
      above = sz > lim;
      ack   = wr_stb && wr_sel && wr_data[3];
      if (soft_clr) begin
        mq.delete(); m_flag = 0; m_rdd = 0; m_cst = 0;
      end else begin
        m_flag = (m_flag && !ack) || above;
        pop  = rd_stb && sz > 0;
        full = sz >= cap;
        if (pop) begin
          m_rdd = mq[0][7:0];
          m_cst = {5'b0, mq[0][10:8]};
          void'(mq.pop_front());
        end
        if (in_valid) begin
          if (!full || pop) mq.push_back({1'b0, in_frm_err, in_par_err, in_data});
          else mq[mq.size()-1][10] = 1'b1;
        end
      end
      if (wr_stb && !wr_sel) begin
        m_on = wr_data[3]; m_code = int'(wr_data[2:0]);
      end
    end
  end

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R2 model rd_data", rd_data, m_rdd);
      cmp("R3 model char_status", char_status, m_cst);
      cmp("R6 model fifo_status", fifo_status, {4'b0, m_flag, mq.size() == 0, 2'b0});
      cmp("R10 model rx_req", {7'b0, rx_req}, {7'b0, m_flag});
    end
  end

  task automatic report();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f);
    in_valid = 1; in_data = d; in_par_err = p; in_frm_err = f;
    @(negedge clk);
    in_valid = 0; in_par_err = 0; in_frm_err = 0;
  endtask

  task automatic pop();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic pushpop(input logic [7:0] d);
    in_valid = 1; in_data = d; rd_stb = 1;
    @(negedge clk);
    in_valid = 0; rd_stb = 0;
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_stb = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 0; soft_clr = 0; in_valid = 0; in_data = 0; in_par_err = 0; in_frm_err = 0;
    rd_stb = 0; wr_stb = 0; wr_sel = 0; wr_data = 0;
    idle(3);
    cmp("R12 reset rd_data", rd_data, 8'h00);
    cmp("R12 reset char_status", char_status, 8'h00);
    cmp("R12 reset fifo_status", fifo_status, 8'h04);
    cmp("R12 reset rx_req", {7'b0, rx_req}, 8'h00);
    rst_n = 1;
    idle(2);

    // Single-character mode after reset
    push(8'hA5, 1, 0);
    idle(1);
    cmp("R9 one char sets flag", fifo_status, 8'h08);
    cmp("R9 request in single mode", {7'b0, rx_req}, 8'h01);
    push(8'h3C, 0, 1);
    pop();
    cmp("R4 dropped char not stored", rd_data, 8'hA5);
    cmp("R4 overrun on held char", char_status, 8'h05);
    cmp("R8 flag sticky while empty", fifo_status, 8'h0C);
    wr(1, 4'h8);
    cmp("R8 ack clears flag", fifo_status, 8'h04);
    pop();
    cmp("R5 empty read keeps data", rd_data, 8'hA5);
    cmp("R5 empty read keeps status", char_status, 8'h05);
    cmp("R5 empty read keeps empty", fifo_status, 8'h04);

    // Buffered mode, limit code 0 (limit 8)
    wr(0, 4'h8);
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i), 0, i == 3);
    idle(2);
    cmp("R7 eight stored no request", {7'b0, rx_req}, 8'h00);
    push(8'h18, 0, 0);
    cmp("R7 flag one edge after level", {7'b0, rx_req}, 8'h00);
    idle(1);
    cmp("R7 nine stored raises request", {7'b0, rx_req}, 8'h01);
    wr(1, 4'h8);
    cmp("R8 ack while above keeps flag", {7'b0, rx_req}, 8'h01);
    pop();
    cmp("R1 first out", rd_data, 8'h10);
    wr(1, 4'h7);
    cmp("R8 write without ack bit ignored", {7'b0, rx_req}, 8'h01);
    wr(1, 4'h8);
    cmp("R8 ack at limit clears", {7'b0, rx_req}, 8'h00);
    for (int i = 1; i < 9; i++) begin
      pop();
      cmp("R1 order", rd_data, 8'h10 + 8'(i));
      cmp("R3 framing flag kept", char_status, (i == 3) ? 8'h02 : 8'h00);
    end

    // Limit code 7 (limit 15), full store, overrun and pass-through
    wr(0, 4'hF);
    for (int i = 0; i < 15; i++) push(8'h40 + 8'(i), 0, 0);
    idle(2);
    cmp("R7 fifteen stored no request", {7'b0, rx_req}, 8'h00);
    push(8'h4F, 0, 0);
    idle(1);
    cmp("R7 sixteen raises request", {7'b0, rx_req}, 8'h01);
    push(8'h50, 1, 1);
    pushpop(8'h51);
    cmp("R4 pop with arrival when full", rd_data, 8'h40);
    cmp("R1 still full not empty", {7'b0, fifo_status[2]}, 8'h00);
    for (int i = 1; i < 16; i++) begin
      pop();
      cmp("R1 order deep", rd_data, 8'h40 + 8'(i));
      cmp("R4 overrun only on newest", char_status, (i == 15) ? 8'h04 : 8'h00);
    end
    pop();
    cmp("R4 arrival with pop accepted", rd_data, 8'h51);
    cmp("R4 accepted char clean", char_status, 8'h00);

    // Soft clear
    push(8'h61, 1, 0); push(8'h62, 0, 0); push(8'h63, 0, 0);
    pop();
    soft_clr = 1; in_valid = 1; in_data = 8'h99;
    @(negedge clk);
    soft_clr = 0; in_valid = 0;
    cmp("R11 clear empties", fifo_status, 8'h04);
    cmp("R11 clear zeroes data", rd_data, 8'h00);
    cmp("R11 clear zeroes status", char_status, 8'h00);
    for (int i = 0; i < 9; i++) push(8'h70 + 8'(i), 0, 0);
    idle(2);
    cmp("R11 limit code retained", {7'b0, rx_req}, 8'h00);
    pop();
    cmp("R11 old entries gone", rd_data, 8'h70);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      in_valid   = ($urandom % 2) == 0;
      in_data    = 8'($urandom);
      in_par_err = ($urandom % 5) == 0;
      in_frm_err = ($urandom % 7) == 0;
      rd_stb     = ($urandom % 5) < 2;
      wr_stb     = ($urandom % 16) == 0;
      wr_sel     = ($urandom % 2) == 0;
      wr_data    = 4'($urandom) | 4'h8;
      if (($urandom % 8) == 0) wr_data[3] = 1'b0;
      soft_clr   = ($urandom % 300) == 0;
      @(negedge clk);
    end
    in_valid = 0; rd_stb = 0; wr_stb = 0; soft_clr = 0;
    idle(3);
    report();
  end

endmodule